// File: doc/BRIEF.md
# Strobed serial command port

This block is the host-side serial port of a display controller. The host pulls a strobe low, toggles a shift clock and presents data one bit at a time, least significant bit first. The port samples the data line on rising shift-clock edges and packs the bits into bytes. The first whole byte after the strobe falls is handed to the rest of the design as a command. Later whole bytes are either handed on as write data, or, if the command asked for a read, answered with bytes that the port shifts out to the host.

All three host pins are brought into the system clock domain through synchronising flops, because they come from slow Schmitt-trigger inputs. Their edges are detected in that domain. The returned data line is open-drain. The port only ever pulls it low or lets it go, so it appears as an output enable paired with a data pin tied to zero. Read mode is chosen when the command byte, masked by `RD_MASK`, equals `RD_MATCH`. By default this means bits [1:0] equal 2'b10.

Top module: `ssp_port`

## Requirements
- R1: While the strobe pin is high, shift-clock and data activity have no effect. No byte pulse and no read load occur, and the output enable stays low.
- R2: The first complete byte after the strobe falls appears on `cmd_byte` with a `cmd_valid` pulse that lasts one clock cycle. It is the only such pulse in that strobe-low period.
- R3: The data pin is sampled on shift-clock rising edges. The first bit sampled becomes bit 0 of the byte.
- R4: If the command does not select read mode, each later complete byte appears on `wr_byte` with a `wr_valid` pulse that lasts one clock cycle.
- R5: When the strobe rises in the middle of a byte, that partial byte is dropped. The first byte after the next strobe fall is again a command.
- R6: A command byte with `(cmd & RD_MASK) == RD_MATCH` puts the port into read mode for the rest of that strobe-low period.
- R7: In read mode, `rd_load` pulses in the same cycle as the command pulse, and again at the end of every later complete byte. The value of `rd_byte` in that cycle is the byte that will be sent next.
- R8: In read mode, the output line changes after shift-clock falling edges and sends the loaded byte bit 0 first. The host reads each bit before the next rising edge.
- R9: The output is open-drain. `sdo_o` is always 0, and `sdo_oe` is high only in read mode, and only while the current bit is 0.
- R10: In read mode, no `wr_valid` pulse is produced.
- R11: `cmd_valid` and `wr_valid` are never high in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_pin | input | 1 | Host strobe, active low |
| sck_pin | input | 1 | Host shift clock |
| sdi_pin | input | 1 | Host serial data in |
| sdo_oe | output | 1 | Open-drain pull-down enable for the data out line |
| sdo_o | output | 1 | Data out level, tied to 0 |
| cmd_valid | output | 1 | One-cycle command byte strobe |
| cmd_byte | output | DATA_W | Command byte |
| wr_valid | output | 1 | One-cycle write byte strobe |
| wr_byte | output | DATA_W | Write byte |
| rd_load | output | 1 | Request and capture of the next read byte |
| rd_byte | input | DATA_W | Next byte to send in read mode |

## Verification
The assertions assume that the host pins change far more slowly than the system clock. They also assume that the strobe never moves within a few system cycles of a shift-clock edge, so that the three synchronised pins are seen in the order the host drove them. The stimulus keeps to this by holding each shift-clock half period for eight system cycles, and by waiting one full half period between a strobe change and the next clock edge. Randomised commands, byte counts and aborted partial bytes are all driven with those spacings kept.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    SSP_CMD   = 2'd0,
    SSP_WRITE = 2'd1,
    SSP_READ  = 2'd2
  } ssp_mode_e;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssp_edge.sv
module ssp_edge #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q, sr_d, data_q, data_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    data_d = data_q;
    done_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (shift_i) begin
      sr_d = {bit_i, sr_q[DATA_W-1:1]};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
        data_d = sr_d;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      data_q <= data_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              out_q, out_d;

  always_comb begin
    sr_d  = sr_q;
    out_d = out_q;
    if (load_i) begin
      sr_d  = load_data_i;
      out_d = 1'b1;
    end else if (shift_i) begin
      out_d = sr_q[0];
      sr_d  = {1'b1, sr_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '1;
      out_q <= 1'b1;
    end else begin
      sr_q  <= sr_d;
      out_q <= out_d;
    end
  end

  assign bit_o = out_q;
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RD_MASK  = DATA_W'(3),
  parameter logic [DATA_W-1:0] RD_MATCH = DATA_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_pin,
  input  logic              sck_pin,
  input  logic              sdi_pin,
  output logic              sdo_oe,
  output logic              sdo_o,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_byte,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_byte,
  output logic              rd_load,
  input  logic [DATA_W-1:0] rd_byte
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // pin synchronisers, order {sdi, sck, stb}; idle strobe and clock high
  logic [2:0] pins_s;
  logic       stb_hi, sck_s, sdi_s, sck_rise, sck_fall;

  ssp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_core_n),
    .async_i({sdi_pin, sck_pin, stb_pin}), .sync_o(pins_s)
  );
  assign stb_hi = pins_s[0];
  assign sck_s  = pins_s[1];
  assign sdi_s  = pins_s[2];

  ssp_edge #(.WIDTH(1), .RST_VAL(1'b1)) u_edge (
    .clk(clk), .rst_n(rst_core_n),
    .sig_i(sck_s), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  // byte assembly
  logic              rx_done;
  logic [DATA_W-1:0] rx_data;

  ssp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_core_n),
    .clr_i(stb_hi), .shift_i(sck_rise), .bit_i(sdi_s),
    .done_o(rx_done), .data_o(rx_data)
  );

  // byte stage state
  ssp_mode_e mode_q, mode_d;
  logic      cmd_is_rd;

  assign cmd_is_rd = (rx_data & RD_MASK) == RD_MATCH;

  always_comb begin
    mode_d = mode_q;
    if (stb_hi) begin
      mode_d = SSP_CMD;
    end else if (rx_done && mode_q == SSP_CMD) begin
      mode_d = cmd_is_rd ? SSP_READ : SSP_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) mode_q <= SSP_CMD;
    else             mode_q <= mode_d;
  end

  assign cmd_valid = rx_done && (mode_q == SSP_CMD);
  assign wr_valid  = rx_done && (mode_q == SSP_WRITE);
  assign rd_load   = rx_done && ((mode_q == SSP_READ) ||
                                 (mode_q == SSP_CMD && cmd_is_rd));
  assign cmd_byte  = rx_data;
  assign wr_byte   = rx_data;

  // read shifter, one bit per falling shift-clock edge
  logic tx_bit, tx_shift;

  assign tx_shift = sck_fall && !stb_hi && (mode_q == SSP_READ);

  ssp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_core_n),
    .load_i(rd_load), .load_data_i(rd_byte),
    .shift_i(tx_shift), .bit_o(tx_bit)
  );

  assign sdo_oe = (mode_q == SSP_READ) && !tx_bit;
  assign sdo_o  = 1'b0;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RD_MASK  = DATA_W'(3),
  parameter logic [DATA_W-1:0] RD_MATCH = DATA_W'(2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb_pin,
  input logic              sdo_oe,
  input logic              cmd_valid,
  input logic [DATA_W-1:0] cmd_byte,
  input logic              wr_valid,
  input logic              rd_load
);
  logic [2:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= 3'd0;
    else if (!stb_pin)       hi_cnt <= 3'd0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
  end

  assert_idle_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt >= 3'd5) |-> (!cmd_valid && !wr_valid && !rd_load && !sdo_oe));

  assert_cmd_one_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_wr_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_read_cmd_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ((cmd_byte & RD_MASK) == RD_MATCH)) |-> rd_load);

  assert_write_cmd_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ((cmd_byte & RD_MASK) != RD_MATCH)) |-> !rd_load);

  assert_load_not_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |-> !wr_valid);

  assert_pulses_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && wr_valid));
endmodule

bind ssp_port ssp_port_chk #(
  .DATA_W(DATA_W), .RD_MASK(RD_MASK), .RD_MATCH(RD_MATCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_pin(stb_pin), .sdo_oe(sdo_oe),
  .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .wr_valid(wr_valid),
  .rd_load(rd_load)
);

// File: tb/ssp_port_test.sv
module ssp_port_test;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb_pin = 1'b1, sck_pin = 1'b1, sdi_pin = 1'b0;
  logic sdo_oe, sdo_o, cmd_valid, wr_valid, rd_load;
  logic [7:0] cmd_byte, wr_byte, rd_byte;

  always #4 clk = ~clk;

  ssp_port uut (
    .clk(clk), .rst_n(rst_n), .stb_pin(stb_pin), .sck_pin(sck_pin),
    .sdi_pin(sdi_pin), .sdo_oe(sdo_oe), .sdo_o(sdo_o),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .wr_valid(wr_valid),
    .wr_byte(wr_byte), .rd_load(rd_load), .rd_byte(rd_byte)
  );

  int n_checks = 0, n_fail = 0;

  function automatic logic [7:0] rd_pat(input int i);
    return 8'(i * 29 + 90) ^ 8'h33;
  endfunction

  function automatic bit is_read(input logic [7:0] c);
    return c[1:0] == 2'b10;
  endfunction

  // read-byte source: next pattern on each load
  int rd_idx = 0;
  always @(posedge clk) if (rst_n && rd_load) rd_idx <= rd_idx + 1;
  assign rd_byte = rd_pat(rd_idx);

  // port monitor, sampled mid-cycle
  logic [7:0] mon_cmd [16];
  logic [7:0] mon_wr  [16];
  int mon_ncmd = 0, mon_nwr = 0, mon_nload = 0, mon_oe = 0;
  int pulse_err = 0, drive_err = 0;
  logic prev_cmd = 1'b0, prev_wr = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        if (mon_ncmd < 16) mon_cmd[mon_ncmd] = cmd_byte;
        mon_ncmd++;
      end
      if (wr_valid) begin
        if (mon_nwr < 16) mon_wr[mon_nwr] = wr_byte;
        mon_nwr++;
      end
      if (rd_load) mon_nload++;
      if (sdo_oe) mon_oe++;
      if (sdo_o !== 1'b0) drive_err++;
      if ((cmd_valid && prev_cmd) || (wr_valid && prev_wr) || (cmd_valid && wr_valid))
        pulse_err++;
      prev_cmd = cmd_valid;
      prev_wr  = wr_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_ncmd = 0; mon_nwr = 0; mon_nload = 0; mon_oe = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one host bit: falling edge with new data, sample the line, rising edge
  task automatic host_bit(input logic b, output logic seen);
    sck_pin = 1'b0;
    sdi_pin = b;
    wait_cyc(H);
    seen = sdo_oe ? 1'b0 : 1'b1;
    sck_pin = 1'b1;
    wait_cyc(H);
  endtask

  int exp_loads = 0;

  // cmd_bits < 8 aborts inside the command byte
  task automatic txn(input logic [7:0] cmd, input int nbytes, input int partial,
                     input int cmd_bits);
    logic [7:0] wdat [8];
    logic [7:0] got  [8];
    logic seen;
    bit rd, full;
    int base;
    rd = is_read(cmd);
    full = (cmd_bits == 8);
    base = exp_loads;
    for (int j = 0; j < 8; j++) wdat[j] = 8'($urandom);
    clear_mon();
    stb_pin = 1'b0;
    wait_cyc(H);
    for (int b = 0; b < cmd_bits; b++) host_bit(cmd[b], seen);
    if (full) begin
      for (int j = 0; j < nbytes; j++)
        for (int b = 0; b < 8; b++) begin
          host_bit(wdat[j][b], seen);
          got[j][b] = seen;
        end
      for (int b = 0; b < partial; b++) host_bit(1'b1, seen);
    end
    wait_cyc(H);
    stb_pin = 1'b1;
    wait_cyc(2 * H);
    chk(!sdo_oe, "R9", "line released after strobe", 32'(sdo_oe), 0);
    if (!full) begin
      chk(mon_ncmd == 0, "R5", "aborted command pulses", mon_ncmd, 0);
      chk(mon_nwr == 0 && mon_nload == 0, "R5", "aborted command events",
          mon_nwr + mon_nload, 0);
    end else begin
      chk(mon_ncmd == 1, "R2", "command pulse count", mon_ncmd, 1);
      if (mon_ncmd >= 1)
        chk(mon_cmd[0] == cmd, "R3", "command byte", 32'(mon_cmd[0]), 32'(cmd));
      if (!rd) begin
        chk(mon_nwr == nbytes, "R4_R5", "write byte count", mon_nwr, nbytes);
        for (int j = 0; j < nbytes && j < mon_nwr; j++)
          chk(mon_wr[j] == wdat[j], "R4", "write byte", 32'(mon_wr[j]), 32'(wdat[j]));
        chk(mon_nload == 0, "R6", "loads in write mode", mon_nload, 0);
        chk(mon_oe == 0, "R9", "pull-down in write mode", mon_oe, 0);
      end else begin
        exp_loads = base + nbytes + 1;
        chk(mon_nwr == 0, "R10", "write pulses in read mode", mon_nwr, 0);
        chk(mon_nload == nbytes + 1, "R7", "load count", mon_nload, nbytes + 1);
        for (int j = 0; j < nbytes; j++)
          chk(got[j] == rd_pat(base + j), "R8", "read byte", 32'(got[j]),
              32'(rd_pat(base + j)));
      end
    end
  endtask

  bit done = 1'b0;

  initial begin
    void'($urandom(32'd4711));
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(!cmd_valid && !wr_valid && !rd_load, "R1", "pulses after reset",
        32'({cmd_valid, wr_valid, rd_load}), 0);
    chk(!sdo_oe, "R9", "line released after reset", 32'(sdo_oe), 0);

    // directed: write, read, abort in data, abort in command
    txn(8'h40, 3, 0, 8);
    txn(8'h02, 3, 0, 8);
    txn(8'hC1, 1, 5, 8);
    txn(8'h44, 2, 0, 8);
    txn(8'h12, 2, 3, 8);
    txn(8'h04, 0, 0, 5);
    txn(8'h81, 0, 0, 8);

    // R1: strobe held high while the clock and data toggle
    clear_mon();
    for (int i = 0; i < 24; i++) begin
      logic s;
      host_bit(1'(i % 3 == 0), s);
      chk(s == 1'b1, "R1", "line level with strobe high", 32'(s), 1);
    end
    chk(mon_ncmd + mon_nwr + mon_nload == 0, "R1", "events with strobe high",
        mon_ncmd + mon_nwr + mon_nload, 0);
    txn(8'h5C, 1, 0, 8);

    // randomised traffic
    for (int t = 0; t < 24; t++) begin
      logic [7:0] c;
      c = 8'($urandom);
      if (t % 3 == 0) c[1:0] = 2'b10;
      txn(c, int'($urandom % 5), int'($urandom % 8),
          (t % 7 == 6) ? int'($urandom % 8) : 8);
    end

    chk(pulse_err == 0, "R11", "pulse overlap or width errors", pulse_err, 0);
    chk(drive_err == 0, "R9", "data level not zero", drive_err, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule